// File: doc/BRIEF.md
# Cache-Link Write Transfer Decoder

This block sits between a cache controller and an on-chip bus master. The controller talks to it through a narrow channel: every write it offers is one data word plus a one-bit control flag, moved by a valid/ready pair. No strobes mark where a transfer starts or what kind it is. The decoder works that out from the position of each write within the transfer. It then issues bus write requests, each made of an address, byte enables, write data, and first/last markers for a burst.

The transfer kind is fixed for each channel by the parameter `XFER_KIND`. With `XFER_KIND = 1`, each transfer is a single write. An address write carries a size code and a byte address. One data write follows it and becomes one request with byte enables. With `XFER_KIND = 2`, each transfer is a cacheline write. An aligned line address is followed by exactly `LINE_WORDS` data words, and the decoder turns them into one burst. Line data must arrive on back-to-back clocks, so a missing beat is reported as a protocol error. Whenever the output register is full and not drained, the input is held not-ready, so a back-pressured line never loses a beat and never counts as broken. The controller gets no status back. The `err_o` pulse is meant for an error monitor.

Top module: `clwr_decoder`

## Requirements
- R1: In cacheline mode, the first write of a transfer is accepted as the line address only if its control flag is 1 and its low two address bits are 0. Otherwise `err_o` is raised. The address write never produces an output request.
- R2: In cacheline mode, the k-th data beat (k = 0 .. `LINE_WORDS`-1) becomes one request with address = line address + 4·k, all byte enables set, and the beat's data. `out_first` is 1 only for k = 0 and `out_last` is 1 only for k = `LINE_WORDS`-1. After the last beat the decoder waits for a new address write.
- R3: In cacheline mode, once the address is taken, a clock edge with `in_ready` = 1 and `in_valid` = 0 before the last beat is a gap error. A beat whose control flag is 0 is also an error. Either one raises `err_o`, produces no request for that cycle, and abandons the line.
- R4: In single mode, bits [31:30] of the address write give the size: 01 = byte, 10 = half-word, 11 = word, 00 = invalid. Bits [29:0] give the byte address, and the request address is that value zero-extended.
- R5: In single mode, a data write produces exactly one request with `out_first` = `out_last` = 1, the latched address, and the write data passed through unchanged. A byte sets the one enable at lane address[1:0]. A half-word sets lanes 0–1 or lanes 2–3, chosen by address[1]. A word sets all four lanes.
- R6: In single mode, size code 00, a half-word with address[0] = 1, or a word with address[1:0] ≠ 0 raises `err_o` at the address write, and no request follows.
- R7: In single mode, the control flag of the data write must be 1 for a byte and 0 for a half-word or word. On a mismatch, `err_o` is raised and no request is made. Idle cycles between the address and data writes are allowed.
- R8: While `out_valid` = 1 and `out_ready` = 0, the request fields stay unchanged. Any write that would produce a request sees `in_ready` = 0, and an idle input during that time is not a gap.
- R9: `err_o` is a one-cycle pulse. During it `in_ready` = 0 and the offered write is not taken. The decoder then waits for a new address write.
- R10: Synchronous active-low reset clears `out_valid` and `err_o`, abandons any transfer, and leaves `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Controller offers a write |
| in_ready | output | 1 | Decoder takes the offered write at this edge |
| in_ctrl | input | 1 | Control flag of the write |
| in_data | input | DATA_W | Address or data word of the write |
| out_valid | output | 1 | Request held on the output |
| out_ready | input | 1 | Downstream takes the request |
| out_addr | output | DATA_W | Request byte address |
| out_be | output | DATA_W/8 | Request byte enables, bit i = byte lane i |
| out_data | output | DATA_W | Request write data |
| out_first | output | 1 | First request of a burst (always 1 in single mode) |
| out_last | output | 1 | Last request of a burst (always 1 in single mode) |
| err_o | output | 1 | One-cycle protocol error pulse |

## Verification
Two functions can act on the same cycle: output back-pressure and the gap-free rule for cacheline data. An idle input cycle in mid-line is an error only when the decoder was ready to take a beat. The bench provokes the overlap by dropping `out_ready` after the second beat and withholding `in_valid` during the stall, then offering the next beat while the output is still blocked. It judges the result by three things: `err_o` stays low, the held request stays unchanged, and every beat then comes out with the right address and markers. A real gap with `out_ready` high must still raise the error pulse, and the write offered during the pulse must not be taken.

// File: rtl/clwr_pkg.sv
// Shared types for the cache-link write decoder.
// Assumes: byte lanes of 8 bits, at least four lanes per word.
package clwr_pkg;

    // Decoder phases: waiting for address, address taken, line data, error pulse
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_ERR  = 2'd3
    } clwr_state_e;

    // Access size code carried in the two top bits of a single-write address
    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_WORD = 2'b11
    } clwr_size_e;

    // Transfer kind selector values
    localparam int unsigned XFER_SINGLE = 1;
    localparam int unsigned XFER_LINE   = 2;

endpackage

// File: rtl/clwr_lane_enable.sv
// Byte-enable generator.
// Turns an access size and the low byte-offset bits into a lane mask and
// reports whether the access is naturally aligned. A rejected access
// (invalid size or misaligned) yields an all-zero mask.
// Assumes: LANES is a power of two and at least 4.
module clwr_lane_enable
    import clwr_pkg::*;
#(
    parameter int unsigned LANES = 4,
    localparam int unsigned OFF_W = $clog2(LANES)
) (
    input  clwr_size_e         size_i,
    input  logic [OFF_W-1:0]   off_i,
    output logic [LANES-1:0]   be_o,
    output logic               ok_o
);

    logic [OFF_W:0] nbytes;
    logic [OFF_W:0] off_ext;

    // Number of bytes touched by the access
    always_comb begin
        unique case (size_i)
            SZ_BYTE: nbytes = (OFF_W+1)'(1);
            SZ_HALF: nbytes = (OFF_W+1)'(2);
            SZ_WORD: nbytes = (OFF_W+1)'(LANES);
            default: nbytes = '0;
        endcase
    end

    assign off_ext = {1'b0, off_i};

    // Natural alignment: offset is a multiple of the access size
    assign ok_o = (size_i != SZ_NONE) && ((off_ext & (nbytes - 1'b1)) == '0);

    // One comparator pair per lane
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W:0] LANE_IDX = (OFF_W+1)'(i);
        assign be_o[i] = ok_o && (LANE_IDX >= off_ext) && (LANE_IDX < off_ext + nbytes);
    end

endmodule

// File: rtl/clwr_frame_fsm.sv
// Transfer framing state machine.
// Tracks the position of each incoming write within its transfer, checks the
// protocol (address form, size/flag agreement, gap-free line data), and
// produces a load strobe with request fields for the output stage.
// Assumes: slot_free_i is high when the output stage can take a request at
// this edge; the decoder only takes a data write when it is.
module clwr_frame_fsm
    import clwr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned XFER_KIND  = XFER_SINGLE,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned OFF_W = $clog2(LANES),
    localparam int unsigned CNT_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              in_ctrl_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              slot_free_i,
    output logic              in_ready_o,
    output logic              ld_en_o,
    output logic [DATA_W-1:0] ld_addr_o,
    output logic [LANES-1:0]  ld_be_o,
    output logic [DATA_W-1:0] ld_data_o,
    output logic              ld_first_o,
    output logic              ld_last_o,
    output logic              err_o
);

    localparam bit IS_LINE = (XFER_KIND == XFER_LINE);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINE_WORDS - 1);

    clwr_state_e       state_q, state_d;
    logic [DATA_W-1:0] base_q;
    clwr_size_e        size_q;
    logic [CNT_W-1:0]  cnt_q;

    clwr_size_e        lane_size;
    logic [OFF_W-1:0]  lane_off;
    logic [LANES-1:0]  lane_be;
    logic              lane_ok;
    logic              last_beat;
    logic              byte_flag;

    // Lane decoder sees the offered address in idle, the latched one later
    assign lane_size = (state_q == ST_IDLE) ? clwr_size_e'(in_data_i[DATA_W-1 -: 2]) : size_q;
    assign lane_off  = (state_q == ST_IDLE) ? in_data_i[OFF_W-1:0] : base_q[OFF_W-1:0];

    clwr_lane_enable #(
        .LANES (LANES)
    ) u_lanes (
        .size_i (lane_size),
        .off_i  (lane_off),
        .be_o   (lane_be),
        .ok_o   (lane_ok)
    );

    assign last_beat = (cnt_q == LAST_IDX);
    assign byte_flag = (size_q == SZ_BYTE);

    // Request fields: line beats step by one word, single writes use the mask
    assign ld_data_o = in_data_i;
    assign ld_addr_o = IS_LINE ? (base_q + (DATA_W'(cnt_q) << OFF_W)) : base_q;
    assign ld_be_o   = IS_LINE ? {LANES{1'b1}} : lane_be;
    assign err_o     = (state_q == ST_ERR);

    // Input readiness: data phases wait for room in the output stage
    always_comb begin
        unique case (state_q)
            ST_IDLE:          in_ready_o = 1'b1;
            ST_ADDR, ST_DATA: in_ready_o = slot_free_i;
            default:          in_ready_o = 1'b0;
        endcase
    end

    // Next-state and load decision
    always_comb begin
        state_d    = state_q;
        ld_en_o    = 1'b0;
        ld_first_o = 1'b0;
        ld_last_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid_i) begin
                    if (IS_LINE) begin
                        state_d = (in_ctrl_i && (in_data_i[OFF_W-1:0] == '0)) ? ST_ADDR : ST_ERR;
                    end else begin
                        state_d = lane_ok ? ST_ADDR : ST_ERR;
                    end
                end
            end
            ST_ADDR: begin
                if (IS_LINE) begin
                    if (slot_free_i) begin
                        if (!in_valid_i || !in_ctrl_i) begin
                            state_d = ST_ERR;
                        end else begin
                            ld_en_o    = 1'b1;
                            ld_first_o = 1'b1;
                            ld_last_o  = last_beat;
                            state_d    = last_beat ? ST_IDLE : ST_DATA;
                        end
                    end
                end else if (in_valid_i && slot_free_i) begin
                    if (in_ctrl_i != byte_flag) begin
                        state_d = ST_ERR;
                    end else begin
                        ld_en_o    = 1'b1;
                        ld_first_o = 1'b1;
                        ld_last_o  = 1'b1;
                        state_d    = ST_IDLE;
                    end
                end
            end
            ST_DATA: begin
                if (slot_free_i) begin
                    if (!in_valid_i || !in_ctrl_i) begin
                        state_d = ST_ERR;
                    end else begin
                        ld_en_o   = 1'b1;
                        ld_last_o = last_beat;
                        state_d   = last_beat ? ST_IDLE : ST_DATA;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Address and size capture on the address write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= SZ_NONE;
        end else if (state_q == ST_IDLE && in_valid_i) begin
            base_q <= IS_LINE ? in_data_i : {2'b00, in_data_i[DATA_W-3:0]};
            size_q <= clwr_size_e'(in_data_i[DATA_W-1 -: 2]);
        end
    end

    // Beat counter within a line
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_IDLE) cnt_q <= '0;
        else if (ld_en_o)                 cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/clwr_out_stage.sv
// Output request register with valid/ready handshake.
// Holds one request until the downstream side takes it.
// Assumes: ld_en_i is only raised when slot_free_o is high.
module clwr_out_stage #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en_i,
    input  logic [DATA_W-1:0] ld_addr_i,
    input  logic [LANES-1:0]  ld_be_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic              ld_first_i,
    input  logic              ld_last_i,
    input  logic              out_ready_i,
    output logic              slot_free_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_addr_o,
    output logic [LANES-1:0]  out_be_o,
    output logic [DATA_W-1:0] out_data_o,
    output logic              out_first_o,
    output logic              out_last_o
);

    // Room for a new request when empty or being drained this edge
    assign slot_free_o = !out_valid_o || out_ready_i;

    // Valid flag: set on load, cleared on handshake
    always_ff @(posedge clk) begin
        if (!rst_n)           out_valid_o <= 1'b0;
        else if (ld_en_i)     out_valid_o <= 1'b1;
        else if (out_ready_i) out_valid_o <= 1'b0;
    end

    // Request fields captured on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_addr_o  <= '0;
            out_be_o    <= '0;
            out_data_o  <= '0;
            out_first_o <= 1'b0;
            out_last_o  <= 1'b0;
        end else if (ld_en_i) begin
            out_addr_o  <= ld_addr_i;
            out_be_o    <= ld_be_i;
            out_data_o  <= ld_data_i;
            out_first_o <= ld_first_i;
            out_last_o  <= ld_last_i;
        end
    end

endmodule

// File: rtl/clwr_decoder.sv
// Cache-link write transfer decoder, top level.
// Frames the controller's write stream by position and issues bus write
// requests; XFER_KIND selects single (1) or cacheline (2) transfers.
// Assumes: DATA_W is a multiple of 32 lanes-wise (at least four byte lanes)
// and LINE_WORDS is at least 2 for cacheline mode.
module clwr_decoder
    import clwr_pkg::*;
#(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned XFER_KIND  = XFER_SINGLE,
    localparam int unsigned LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_ctrl,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_addr,
    output logic [LANES-1:0]  out_be,
    output logic [DATA_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              err_o
);

    logic              slot_free;
    logic              ld_en;
    logic [DATA_W-1:0] ld_addr;
    logic [LANES-1:0]  ld_be;
    logic [DATA_W-1:0] ld_data;
    logic              ld_first;
    logic              ld_last;

    clwr_frame_fsm #(
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS),
        .XFER_KIND  (XFER_KIND)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_ctrl_i   (in_ctrl),
        .in_data_i   (in_data),
        .slot_free_i (slot_free),
        .in_ready_o  (in_ready),
        .ld_en_o     (ld_en),
        .ld_addr_o   (ld_addr),
        .ld_be_o     (ld_be),
        .ld_data_o   (ld_data),
        .ld_first_o  (ld_first),
        .ld_last_o   (ld_last),
        .err_o       (err_o)
    );

    clwr_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_en_i     (ld_en),
        .ld_addr_i   (ld_addr),
        .ld_be_i     (ld_be),
        .ld_data_i   (ld_data),
        .ld_first_i  (ld_first),
        .ld_last_i   (ld_last),
        .out_ready_i (out_ready),
        .slot_free_o (slot_free),
        .out_valid_o (out_valid),
        .out_addr_o  (out_addr),
        .out_be_o    (out_be),
        .out_data_o  (out_data),
        .out_first_o (out_first),
        .out_last_o  (out_last)
    );

endmodule

// File: rtl/clwr_decoder_chk.sv
// Protocol checker for clwr_decoder, attached by bind.
// Watches the request handshake, burst markers and the error pulse.
module clwr_decoder_chk #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned XFER_KIND  = 1,
    localparam int unsigned LANES = DATA_W / 8,
    localparam int unsigned CNT_W = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_addr,
    input logic [LANES-1:0]  out_be,
    input logic [DATA_W-1:0] out_data,
    input logic              out_first,
    input logic              out_last,
    input logic              err_o
);

    logic [CNT_W-1:0] beat_idx;

    // Index of the next request within the current burst
    always_ff @(posedge clk) begin
        if (!rst_n)                      beat_idx <= '0;
        else if (out_valid && out_ready) beat_idx <= out_last ? '0 : (out_first ? CNT_W'(1) : beat_idx + 1'b1);
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_data)
            && $stable(out_be) && $stable(out_first) && $stable(out_last)); // R8

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R9

    AST_ERR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !in_ready); // R9

    AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_be != '0)); // R5

    AST_LINE_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (XFER_KIND == 2) && out_valid |-> (&out_be)); // R2

    AST_LINE_LAST_POS: assert property (@(posedge clk) disable iff (!rst_n)
        (XFER_KIND == 2) && out_valid && out_last && !out_first |-> (beat_idx == CNT_W'(LINE_WORDS - 1))); // R2

    AST_SINGLE_MARKERS: assert property (@(posedge clk) disable iff (!rst_n)
        (XFER_KIND == 1) && out_valid |-> out_first && out_last); // R5

endmodule

bind clwr_decoder clwr_decoder_chk #(
    .DATA_W     (DATA_W),
    .LINE_WORDS (LINE_WORDS),
    .XFER_KIND  (XFER_KIND)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_addr  (out_addr),
    .out_be    (out_be),
    .out_data  (out_data),
    .out_first (out_first),
    .out_last  (out_last),
    .err_o     (err_o)
);

// File: tb/sim_clwr_decoder.sv
// Bench: u0 runs cacheline mode (4-word lines), u1 runs single-write mode.
module sim_clwr_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // u0 (cacheline) signals
    logic        a_valid = 1'b0, a_ctrl = 1'b0, a_oready = 1'b1;
    logic [31:0] a_data = '0;
    logic        a_ready, a_ovalid, a_first, a_last, a_err;
    logic [31:0] a_addr, a_odata;
    logic [3:0]  a_be;

    // u1 (single) signals
    logic        b_valid = 1'b0, b_ctrl = 1'b0, b_oready = 1'b1;
    logic [31:0] b_data = '0;
    logic        b_ready, b_ovalid, b_first, b_last, b_err;
    logic [31:0] b_addr, b_odata;
    logic [3:0]  b_be;

    clwr_decoder #(.DATA_W(32), .LINE_WORDS(4), .XFER_KIND(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready),
        .in_ctrl(a_ctrl), .in_data(a_data), .out_valid(a_ovalid), .out_ready(a_oready),
        .out_addr(a_addr), .out_be(a_be), .out_data(a_odata),
        .out_first(a_first), .out_last(a_last), .err_o(a_err));

    clwr_decoder #(.DATA_W(32), .LINE_WORDS(4), .XFER_KIND(1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready),
        .in_ctrl(b_ctrl), .in_data(b_data), .out_valid(b_ovalid), .out_ready(b_oready),
        .out_addr(b_addr), .out_be(b_be), .out_data(b_odata),
        .out_first(b_first), .out_last(b_last), .err_o(b_err));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Single-write vectors: {size[16:15], addr[14:7], ctrl[6], errphase[5:4], be[3:0]}
    // errphase 0 = request, 1 = rejected at address, 2 = rejected at data
    localparam logic [16:0] SVEC [12] = '{
        {2'b01, 8'h40, 1'b1, 2'd0, 4'b0001},
        {2'b01, 8'h41, 1'b1, 2'd0, 4'b0010},
        {2'b01, 8'h42, 1'b1, 2'd0, 4'b0100},
        {2'b01, 8'h43, 1'b1, 2'd0, 4'b1000},
        {2'b10, 8'h44, 1'b0, 2'd0, 4'b0011},
        {2'b10, 8'h46, 1'b0, 2'd0, 4'b1100},
        {2'b11, 8'h48, 1'b0, 2'd0, 4'b1111},
        {2'b10, 8'h45, 1'b0, 2'd1, 4'b0000},
        {2'b11, 8'h4A, 1'b0, 2'd1, 4'b0000},
        {2'b00, 8'h4C, 1'b0, 2'd1, 4'b0000},
        {2'b01, 8'h4D, 1'b0, 2'd2, 4'b0000},
        {2'b11, 8'h50, 1'b1, 2'd2, 4'b0000}
    };

    localparam logic [31:0] LBASE = 32'h0000_2040;
    localparam logic [31:0] LDATA = 32'hD000_0000;

    // Send one cacheline address write
    task automatic line_addr(input logic [31:0] adr, input logic ctl);
        a_valid = 1'b1; a_ctrl = ctl; a_data = adr;
        tick();
    endtask

    // Send one beat and check the resulting request
    task automatic line_beat(input int k);
        a_valid = 1'b1; a_ctrl = 1'b1; a_data = LDATA + 32'(k);
        tick();
        chk("R2", "beat valid", {31'b0, a_ovalid}, 32'd1);
        chk("R2", "beat addr", a_addr, LBASE + 32'(4 * k));
        chk("R2", "beat be", {28'b0, a_be}, 32'hF);
        chk("R2", "beat data", a_odata, LDATA + 32'(k));
        chk("R2", "beat first", {31'b0, a_first}, {31'b0, k == 0});
        chk("R2", "beat last", {31'b0, a_last}, {31'b0, k == 3});
    endtask

    initial begin
        // Reset state (R10)
        repeat (3) tick();
        chk("R10", "u0 out_valid", {31'b0, a_ovalid}, 32'd0);
        chk("R10", "u0 err", {31'b0, a_err}, 32'd0);
        chk("R10", "u0 in_ready", {31'b0, a_ready}, 32'd1);
        chk("R10", "u1 out_valid", {31'b0, b_ovalid}, 32'd0);
        rst_n = 1'b1;
        tick();

        // Single-write table walk (R4..R7)
        for (int i = 0; i < 12; i++) begin
            logic [1:0]  sz;
            logic [7:0]  lo;
            logic        ct;
            logic [1:0]  ep;
            logic [3:0]  be;
            logic [31:0] wd;
            {sz, lo, ct, ep, be} = SVEC[i];
            wd = 32'hA500_0000 | 32'(i * 32'h0101_0101 & 32'h00FF_FFFF);
            b_valid = 1'b1; b_ctrl = 1'b0;
            b_data = {sz, 30'(32'h1200 | 32'(lo))};
            tick();
            if (ep == 2'd1) begin
                chk("R6", "reject at address err", {31'b0, b_err}, 32'd1);
                chk("R6", "no request", {31'b0, b_ovalid}, 32'd0);
                b_valid = 1'b0;
                tick();
                continue;
            end
            b_ctrl = ct; b_data = wd;
            tick();
            if (ep == 2'd2) begin
                chk("R7", "flag mismatch err", {31'b0, b_err}, 32'd1);
                chk("R7", "no request", {31'b0, b_ovalid}, 32'd0);
            end else begin
                chk("R5", "single valid", {31'b0, b_ovalid}, 32'd1);
                chk("R5", "single be", {28'b0, b_be}, {28'b0, be});
                chk("R4", "single addr", b_addr, 32'h1200 | 32'(lo));
                chk("R5", "single data", b_odata, wd);
                chk("R5", "single markers", {30'b0, b_first, b_last}, 32'd3);
                chk("R7", "no err", {31'b0, b_err}, 32'd0);
            end
            b_valid = 1'b0;
            tick();
        end

        // Single: idle cycles between address and data are allowed (R7)
        b_valid = 1'b1; b_ctrl = 1'b0; b_data = {2'b11, 30'h0000_3000};
        tick();
        b_valid = 1'b0;
        repeat (3) tick();
        chk("R7", "idle between writes no err", {31'b0, b_err}, 32'd0);
        b_valid = 1'b1; b_ctrl = 1'b0; b_data = 32'h1111_2222;
        tick();
        chk("R7", "late data request", {31'b0, b_ovalid}, 32'd1);
        chk("R7", "late data value", b_odata, 32'h1111_2222);
        b_valid = 1'b0;
        tick();

        // Single: back-pressure (R8)
        b_oready = 1'b0;
        b_valid = 1'b1; b_ctrl = 1'b1; b_data = {2'b01, 30'h0000_3001};
        tick();
        b_data = 32'h0000_AB00;
        tick();
        b_valid = 1'b1; b_ctrl = 1'b0; b_data = {2'b11, 30'h0000_3004};
        tick();
        b_data = 32'h5555_6666;
        #1;
        chk("R8", "single in_ready low while held", {31'b0, b_ready}, 32'd0);
        tick();
        tick();
        chk("R8", "held data stable", b_odata, 32'h0000_AB00);
        chk("R8", "held be stable", {28'b0, b_be}, 32'h2);
        b_oready = 1'b1;
        tick();
        chk("R8", "second after release", b_odata, 32'h5555_6666);
        chk("R8", "second be", {28'b0, b_be}, 32'hF);
        b_valid = 1'b0;
        tick();

        // Cacheline: clean line (R1, R2)
        line_addr(LBASE, 1'b1);
        chk("R1", "address gives no request", {31'b0, a_ovalid}, 32'd0);
        chk("R1", "good address no err", {31'b0, a_err}, 32'd0);
        for (int k = 0; k < 4; k++) line_beat(k);
        a_valid = 1'b0;
        tick();
        chk("R2", "idle after line", {31'b0, a_ovalid}, 32'd0);
        chk("R2", "idle after line no err", {31'b0, a_err}, 32'd0);

        // Cacheline: stall overlapping idle input (R8)
        line_addr(LBASE, 1'b1);
        line_beat(0);
        line_beat(1);
        a_oready = 1'b0; a_valid = 1'b0;
        tick();
        chk("R8", "stall idle no err", {31'b0, a_err}, 32'd0);
        chk("R8", "stall held addr", a_addr, LBASE + 32'd4);
        chk("R8", "stall in_ready", {31'b0, a_ready}, 32'd0);
        a_valid = 1'b1; a_ctrl = 1'b1; a_data = LDATA + 32'd2;
        tick();
        chk("R8", "stall beat not taken", a_odata, LDATA + 32'd1);
        chk("R8", "stall still valid", {31'b0, a_ovalid}, 32'd1);
        a_oready = 1'b1;
        line_beat(2);
        line_beat(3);
        a_valid = 1'b0;
        tick();
        chk("R8", "after stall no err", {31'b0, a_err}, 32'd0);

        // Cacheline: gap mid-line, and write offered during pulse (R3, R9)
        line_addr(LBASE, 1'b1);
        line_beat(0);
        a_valid = 1'b0;
        tick();
        chk("R3", "gap err", {31'b0, a_err}, 32'd1);
        chk("R9", "in_ready low in pulse", {31'b0, a_ready}, 32'd0);
        a_valid = 1'b1; a_ctrl = 1'b1; a_data = LBASE;
        tick();
        chk("R9", "pulse one cycle", {31'b0, a_err}, 32'd0);
        chk("R9", "offered write not taken", {31'b0, a_ovalid}, 32'd0);
        tick();
        chk("R9", "new address taken", {31'b0, a_ovalid}, 32'd0);
        for (int k = 0; k < 4; k++) line_beat(k);
        a_valid = 1'b0;
        tick();

        // Cacheline: gap right after address (R3)
        line_addr(LBASE, 1'b1);
        a_valid = 1'b0;
        tick();
        chk("R3", "gap after address err", {31'b0, a_err}, 32'd1);
        tick();

        // Cacheline: beat with flag 0 (R3)
        line_addr(LBASE, 1'b1);
        line_beat(0);
        a_valid = 1'b1; a_ctrl = 1'b0; a_data = LDATA + 32'd1;
        tick();
        chk("R3", "flag-0 beat err", {31'b0, a_err}, 32'd1);
        chk("R3", "flag-0 beat no request", {31'b0, a_ovalid}, 32'd0);
        a_valid = 1'b0;
        tick();

        // Cacheline: bad address writes (R1)
        line_addr(LBASE, 1'b0);
        chk("R1", "flag-0 address err", {31'b0, a_err}, 32'd1);
        a_valid = 1'b0;
        tick();
        line_addr(LBASE + 32'd2, 1'b1);
        chk("R1", "misaligned address err", {31'b0, a_err}, 32'd1);
        a_valid = 1'b0;
        tick();

        // Reset mid-transfer (R10)
        line_addr(LBASE, 1'b1);
        line_beat(0);
        rst_n = 1'b0; a_valid = 1'b0;
        tick();
        chk("R10", "mid reset out_valid", {31'b0, a_ovalid}, 32'd0);
        chk("R10", "mid reset in_ready", {31'b0, a_ready}, 32'd1);
        chk("R10", "mid reset err", {31'b0, a_err}, 32'd0);
        rst_n = 1'b1;
        tick();
        line_addr(LBASE, 1'b1);
        for (int k = 0; k < 4; k++) line_beat(k);
        a_valid = 1'b0;
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule